// File: doc/BRIEF.md
# Line-Terminator Activation Sequencer

This block is the control state machine at the exchange end of a basic-rate digital subscriber line. It walks the link from an idle, silent condition through a fixed tone burst, a wait for the far end's answering tone, echo-canceller training and framing, and finally into full data transfer. It also tears the link back down on a local request or when basic-frame alignment stays lost for too long.

Each state selects one transmit-signal kind, published as a 3-bit code for the signal generator. The state itself is published as a 4-bit code for status. Five internal counters advance on a symbol-rate tick. Four of them are supervision timers and one times the tone burst. Each is started and stopped explicitly by state transitions. Their lengths are parameters in symbol ticks, so a bench can shrink them.

Top module: `lt_act_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state becomes full-reset (state code 0), the transmit code becomes silence (0), and all timers stop.
- R2: In full-reset, `act_req` moves the machine to alerting (state 1), which sends tone (transmit code 1) for exactly `TONE_TICKS` ticks. The machine then enters awaiting-reply (state 2, silence). The activation request also starts the overall timer T0.
- R3: All timers, including the tone burst, advance only on edges where `sym_tick` is high.
- R4: In full-reset, awaiting-reply or receive-reset, `tone_rx` moves the machine to awake (state 3, silence). This transition restarts T0 and stops T2.
- R5: Awake moves to training (state 4, transmit code 2 = framed training signal) once `tone_rx` is low.
- R6: Training moves to framing (state 5, transmit code 3 = framed and superframed signal) only when `far_end_done` and `ec_conv` are both high.
- R7: In framing, `sfs` moves the machine to active (state 7, transmit code 4 = full data) and stops T0, so active persists past any T0 length.
- R8: When T0 expires `T0_TICKS` ticks after its last start, in any of states 1 to 5, the machine enters receive-reset (state 9, silence) and starts T2.
- R9: Receive-reset returns to full-reset `T2_TICKS` ticks after entry.
- R10: In active, `deact_req` moves the machine to pending-deactivation (state 8, silence) and starts T3.
- R11: In active, `bfs` held low for `T1_TICKS` ticks moves the machine to pending-deactivation. A return of `bfs` to high cancels the count.
- R12: Pending-deactivation moves to receive-reset when `los` and `deact_req` are both high, or when T3 expires `T3_TICKS` ticks after entry. `los` alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset, synchronous |
| sym_tick | input | 1 | Symbol-rate enable for all timers |
| act_req | input | 1 | Local activation request |
| deact_req | input | 1 | Local deactivation request |
| tone_rx | input | 1 | Far-end activation tone detected |
| far_end_done | input | 1 | Far-end training signal has ended |
| ec_conv | input | 1 | Echo canceller converged |
| sfs | input | 1 | Superframe sync acquired |
| bfs | input | 1 | Basic-frame sync held |
| los | input | 1 | Loss of received signal |
| tx_sig | output | 3 | Transmit signal kind: 0 silence, 1 tone, 2 framed training, 3 framed+superframed, 4 full data |
| state_code | output | 4 | Current state code |

## Verification
The bench counts the tone burst and each timer window to the exact tick and samples on both sides of every expiry. A timer that is off by one therefore shows up as a state change one cycle early or late. It stalls `sym_tick` during the burst, so a counter that ignores the enable would leave alerting too soon. It holds the awake state past the original T0 deadline to prove that the answering tone restarts T0, and stays active past T0 to prove that superframe sync stops it. It breaks frame sync briefly before a long loss to catch a T1 count that does not clear, and it applies `los` without a deactivation request to catch a tear-down that fires on loss of signal alone.

// File: rtl/lt_act_ctrl.sv
module lt_act_ctrl #(
  parameter int unsigned T0_TICKS   = 1200000,
  parameter int unsigned T1_TICKS   = 38400,
  parameter int unsigned T2_TICKS   = 3200,
  parameter int unsigned T3_TICKS   = 41600,
  parameter int unsigned TONE_TICKS = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_tick,
  input  logic       act_req,
  input  logic       deact_req,
  input  logic       tone_rx,
  input  logic       far_end_done,
  input  logic       ec_conv,
  input  logic       sfs,
  input  logic       bfs,
  input  logic       los,
  output logic [2:0] tx_sig,
  output logic [3:0] state_code
);
  localparam int unsigned NT  = 5;
  localparam int unsigned M01 = (T0_TICKS > T1_TICKS) ? T0_TICKS : T1_TICKS;
  localparam int unsigned M23 = (T2_TICKS > T3_TICKS) ? T2_TICKS : T3_TICKS;
  localparam int unsigned M03 = (M01 > M23) ? M01 : M23;
  localparam int unsigned MX  = (M03 > TONE_TICKS) ? M03 : TONE_TICKS;
  localparam int unsigned CW  = $clog2(MX + 1);
  localparam int unsigned LEN [NT] = '{T0_TICKS, T1_TICKS, T2_TICKS, T3_TICKS, TONE_TICKS};
  localparam int TW0 = 0, TW1 = 1, TW2 = 2, TW3 = 3, TTN = 4;

  typedef enum logic [3:0] {
    S_FULL  = 4'd0, S_ALERT = 4'd1, S_WAIT  = 4'd2, S_AWAKE = 4'd3,
    S_TRAIN = 4'd4, S_FRAME = 4'd5, S_ACT   = 4'd7, S_PEND  = 4'd8,
    S_RCV   = 4'd9
  } st_t;

  st_t st, nxt;
  logic [NT-1:0] run, expd, strt, stp;
  logic [CW-1:0] cnt [NT];

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    assign expd[i] = run[i] & sym_tick & (cnt[i] == CW'(LEN[i] - 1));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run[i] <= 1'b0;
        cnt[i] <= '0;
      end else if (strt[i]) begin
        run[i] <= 1'b1;
        cnt[i] <= '0;
      end else if (stp[i] || expd[i]) begin
        run[i] <= 1'b0;
      end else if (run[i] && sym_tick) begin
        cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  wire in_setup = (st == S_ALERT) || (st == S_WAIT) || (st == S_AWAKE) ||
                  (st == S_TRAIN) || (st == S_FRAME);

  always_comb begin
    nxt  = st;
    strt = '0;
    stp  = '0;
    case (st)
      S_FULL: begin
        if (act_req) begin
          nxt = S_ALERT; strt[TW0] = 1'b1; strt[TTN] = 1'b1;
        end else if (tone_rx) begin
          nxt = S_AWAKE; strt[TW0] = 1'b1;
        end
      end
      S_ALERT: if (expd[TTN]) nxt = S_WAIT;
      S_WAIT: if (tone_rx) begin
        nxt = S_AWAKE; strt[TW0] = 1'b1; stp[TW2] = 1'b1;
      end
      S_AWAKE: if (!tone_rx) nxt = S_TRAIN;
      S_TRAIN: if (far_end_done && ec_conv) nxt = S_FRAME;
      S_FRAME: if (sfs) begin
        nxt = S_ACT; stp[TW0] = 1'b1;
      end
      S_ACT: begin
        if (deact_req || expd[TW1]) begin
          nxt = S_PEND; strt[TW3] = 1'b1; stp[TW1] = 1'b1;
        end else if (bfs) begin
          stp[TW1] = 1'b1;
        end else if (!run[TW1]) begin
          strt[TW1] = 1'b1;
        end
      end
      S_PEND: if ((los && deact_req) || expd[TW3]) begin
        nxt = S_RCV; strt[TW2] = 1'b1; stp[TW3] = 1'b1;
      end
      S_RCV: begin
        if (expd[TW2]) begin
          nxt = S_FULL;
        end else if (tone_rx) begin
          nxt = S_AWAKE; strt[TW0] = 1'b1; stp[TW2] = 1'b1;
        end
      end
      default: nxt = S_FULL;
    endcase
    if (in_setup && expd[TW0]) begin
      nxt  = S_RCV;
      strt = '0;
      strt[TW2] = 1'b1;
      stp  = '1;
      stp[TW2] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_FULL;
    else        st <= nxt;
  end

  always_comb begin
    case (st)
      S_ALERT: tx_sig = 3'd1;
      S_TRAIN: tx_sig = 3'd2;
      S_FRAME: tx_sig = 3'd3;
      S_ACT:   tx_sig = 3'd4;
      default: tx_sig = 3'd0;
    endcase
  end

  assign state_code = st;
endmodule

// File: rtl/lt_act_ctrl_chk.sv
module lt_act_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       act_req,
  input logic       deact_req,
  input logic       sfs,
  input logic       far_end_done,
  input logic       ec_conv,
  input logic [2:0] tx_sig,
  input logic [3:0] state_code
);
  // R1
  a_r1_reset_full: assert property (@(posedge clk) !rst_n |=> (state_code == 4'd0 && tx_sig == 3'd0));
  // R2
  a_r2_alert_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 4'd1) |=> (state_code != 4'd1 || ($past(state_code) == 4'd0 && $past(act_req))));
  // R6
  a_r6_frame_needs_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd4 && !(far_end_done && ec_conv)) |=> (state_code != 4'd5));
  // R7
  a_r7_active_needs_sfs: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 4'd7) |=> (state_code != 4'd7 || $past(sfs)));
  // R10
  a_r10_deact_to_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd7 && deact_req) |=> (state_code == 4'd8 && tx_sig == 3'd0));
  // R1
  a_r1_tx_legal: assert property (@(posedge clk) disable iff (!rst_n) tx_sig <= 3'd4);
endmodule

bind lt_act_ctrl lt_act_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .act_req(act_req), .deact_req(deact_req),
  .sfs(sfs), .far_end_done(far_end_done), .ec_conv(ec_conv),
  .tx_sig(tx_sig), .state_code(state_code)
);

// File: tb/sim_lt_act_ctrl.sv
module sim_lt_act_ctrl;
  localparam int PERIOD = 10;
  localparam int T0 = 200, T1 = 20, T2 = 10, T3 = 30, TN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sym_tick = 1'b1, act_req = 1'b0, deact_req = 1'b0;
  logic tone_rx = 1'b0, far_end_done = 1'b0, ec_conv = 1'b0, sfs = 1'b0;
  logic bfs = 1'b1, los = 1'b0;
  logic [2:0] tx_sig;
  logic [3:0] state_code;
  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  lt_act_ctrl #(.T0_TICKS(T0), .T1_TICKS(T1), .T2_TICKS(T2), .T3_TICKS(T3),
                .TONE_TICKS(TN)) u0 (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .act_req(act_req),
    .deact_req(deact_req), .tone_rx(tone_rx), .far_end_done(far_end_done),
    .ec_conv(ec_conv), .sfs(sfs), .bfs(bfs), .los(los),
    .tx_sig(tx_sig), .state_code(state_code));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int st_exp, input int tx_exp);
    total++;
    if (state_code !== 4'(st_exp) || tx_sig !== 3'(tx_exp)) begin
      bad++;
      $display("FAIL %s: state=%0d tx=%0d expected state=%0d tx=%0d",
               req, state_code, tx_sig, st_exp, tx_exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; act_req = 0; deact_req = 0; tone_rx = 0; far_end_done = 0;
    ec_conv = 0; sfs = 0; bfs = 1; los = 0; sym_tick = 1;
    step(2);
    check("R1 reset", 0, 0);
    rst_n = 1'b1;
    step(1);
    check("R1 idle after reset", 0, 0);
  endtask

  task automatic start_alert();
    act_req = 1'b1; step(1); act_req = 1'b0;
  endtask

  task automatic t_tone_timeout();
    do_reset();
    start_alert();
    check("R2 tone start", 1, 1);
    step(TN - 1);
    check("R2 tone last tick", 1, 1);
    step(1);
    check("R2 await after tone", 2, 0);
    step(T0 - 1 - TN);
    check("R8 before T0 expiry", 2, 0);
    step(1);
    check("R8 T0 expiry", 9, 0);
    step(T2 - 1);
    check("R9 before T2 expiry", 9, 0);
    step(1);
    check("R9 T2 expiry", 0, 0);
  endtask

  task automatic t_tick_gate();
    do_reset();
    sym_tick = 1'b0;
    start_alert();
    step(30);
    check("R3 tone frozen", 1, 1);
    sym_tick = 1'b1;
    step(TN - 1);
    check("R3 tone resumed", 1, 1);
    step(1);
    check("R3 tone done", 2, 0);
  endtask

  task automatic go_active();
    do_reset();
    start_alert();
    step(TN);
    tone_rx = 1; step(1); tone_rx = 0; step(1);
    far_end_done = 1; ec_conv = 1; step(1);
    far_end_done = 0; ec_conv = 0;
    sfs = 1; step(1); sfs = 0;
  endtask

  task automatic t_full_path();
    do_reset();
    start_alert();
    step(TN);
    step(150);
    tone_rx = 1; step(1);
    check("R4 reply tone", 3, 0);
    step(100);
    check("R4 T0 restarted", 3, 0);
    tone_rx = 0; step(1);
    check("R5 training", 4, 2);
    far_end_done = 1; step(3);
    check("R6 waits for convergence", 4, 2);
    ec_conv = 1; step(1);
    check("R6 framing", 5, 3);
    far_end_done = 0; ec_conv = 0;
    sfs = 1; step(1); sfs = 0;
    check("R7 active", 7, 4);
    step(T0 + 20);
    check("R7 T0 stopped", 7, 4);
    deact_req = 1; step(1); deact_req = 0;
    check("R10 pending", 8, 0);
    step(T3 - 1);
    check("R12 before T3 expiry", 8, 0);
    step(1);
    check("R12 T3 expiry", 9, 0);
    tone_rx = 1; step(1); tone_rx = 0;
    check("R4 tone in receive-reset", 3, 0);
  endtask

  task automatic t_bfs_loss();
    go_active();
    check("R11 active", 7, 4);
    bfs = 0; step(T1 / 2);
    bfs = 1; step(1);
    bfs = 0; step(T1);
    check("R11 count restarted", 7, 4);
    step(1);
    check("R11 frame loss", 8, 0);
    bfs = 1;
    los = 1; step(5);
    check("R12 los alone ignored", 8, 0);
    deact_req = 1; step(1);
    check("R12 los with deact", 9, 0);
    deact_req = 0; los = 0;
  endtask

  task automatic t_far_start();
    do_reset();
    tone_rx = 1; step(1);
    check("R4 tone from full-reset", 3, 0);
    tone_rx = 0; step(1);
    check("R5 training", 4, 2);
    rst_n = 0; step(1);
    check("R1 master reset mid-train", 0, 0);
    rst_n = 1;
  endtask

  initial begin
    t_tone_timeout();
    t_tick_gate();
    t_full_path();
    t_bfs_loss();
    t_far_start();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule